// File: doc/BRIEF.md
# Debug Breakpoint Match and Status Unit

This block watches a processor's instruction pointer and a set of externally computed data-watch flags against four breakpoint slots. Each slot has an address register and a two-bit kind plus two enable bits held in a shared control register. On every clock the unit works out which slots match. It folds the match vector into the low bits of a status register and asks for a debug exception when any enabled slot matched.

Slots are written through a simple register write port. Matches on disabled slots are still recorded in status, but only on a cycle where the status register is committed at all. That happens when an enabled slot matched or when software-side logic pulses a force strobe. Address comparison for data accesses is done outside the block; the unit only consumes one hit flag per slot. I/O-kind slots never match.

Top module: `dbg_bp_unit`

## Requirements
- R1: There are four slots; a match on slot n sets status bit n (bits 3:0 carry slots 0..3).
- R2: On a commit, status bits 3:0 are replaced by the new match vector (stale bits cleared) and status bits 31:4 keep their previous value.
- R3: A slot of kind 00 (instruction) matches when its address register equals `insn_ptr`.
- R4: A slot of kind 01 (data write) or 11 (data read/write) matches when `watch_hit[n]` is 1, whatever its address register holds.
- R5: A slot of kind 10 (I/O) never matches. The kind of slot n is control bits 17+4n:16+4n.
- R6: Status is committed only on a cycle where an enabled slot matched or `force_upd` is 1; otherwise it holds. Disabled matching slots still set their bit on a commit.
- R7: `dbg_exc_o` is 1 in the cycle after a clock edge at which an enabled slot matched, and 0 otherwise.
- R8: Slot n is enabled when control bit 2n or control bit 2n+1 is 1.
- R9: When `wr_en` is 1, `wr_sel` 0..3 writes address register 0..3, 4 writes control, 5 writes status, 6 and 7 write nothing; in any write cycle no match commit and no exception request happen.
- R10: After reset all registers are zero and `dbg_exc_o` is 0; reset is asserted asynchronously and released after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector |
| wr_data | input | 32 | Register write data |
| insn_ptr | input | 32 | Current instruction pointer |
| watch_hit | input | 4 | Per-slot data-watch hit flags |
| force_upd | input | 1 | Commit status even without an enabled match |
| status_o | output | 32 | Status register |
| dbg_exc_o | output | 1 | Debug exception request |

## Verification
The bench builds the unit with its default four slots and 32-bit registers, which makes every slot kind, both enable bits of every slot and the full status word reachable from the write port. With these values the directed cases can place an enabled and a disabled match in the same cycle, put a match on an I/O slot whose address equals the pointer, and collide a register write with a match. A long random phase then mixes writes, forces and pointers drawn from the programmed addresses.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;

  typedef enum logic [1:0] {
    BP_INSN = 2'b00,
    BP_DWR  = 2'b01,
    BP_IO   = 2'b10,
    BP_DRW  = 2'b11
  } bp_kind_e;

  localparam int unsigned KIND_BASE   = 16;
  localparam int unsigned KIND_STRIDE = 4;
  localparam int unsigned EN_STRIDE   = 2;

endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_SLOTS*DATA_W-1:0]   addr_flat,
  output logic [DATA_W-1:0]             ctrl_o
);

  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_SLOTS);

  logic             ctrl_we;
  logic [DATA_W-1:0] ctrl_q;

  assign ctrl_we = wr_en && (wr_sel == CTRL_SEL);

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
      logic              addr_we;
      logic [DATA_W-1:0] addr_q;

      assign addr_we = wr_en && (wr_sel == SEL_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          addr_q <= '0;
        end else if (addr_we) begin
          addr_q <= wr_data;
        end
      end

      assign addr_flat[g*DATA_W +: DATA_W] = addr_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wr_data;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dbg_bp_slot.sv
module dbg_bp_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] slot_addr,
  input  logic [DATA_W-1:0] insn_ptr,
  input  logic              watch,
  input  logic [1:0]        kind,
  input  logic [1:0]        en_bits,
  output logic              hit,
  output logic              enabled
);
  import dbg_bp_pkg::*;

  bp_kind_e kind_e;

  assign kind_e  = bp_kind_e'(kind);
  assign enabled = |en_bits;

  always_comb begin
    hit = 1'b0;
    unique case (kind_e)
      BP_INSN: hit = (slot_addr == insn_ptr);
      BP_DWR,
      BP_DRW:  hit = watch;
      BP_IO:   hit = 1'b0;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_bp_status.sv
module dbg_bp_status #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_any,
  input  logic                 wr_stat,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [NUM_SLOTS-1:0] hit_vec,
  input  logic [NUM_SLOTS-1:0] en_vec,
  input  logic                 force_upd,
  output logic [DATA_W-1:0]    status_o,
  output logic                 exc_o
);

  logic [DATA_W-1:0] stat_q, stat_d;
  logic              stat_we;
  logic              exc_q, exc_d;
  logic              armed_hit;
  logic [DATA_W-1:0] assembled;

  assign armed_hit = |(hit_vec & en_vec);
  assign assembled = {stat_q[DATA_W-1:NUM_SLOTS], hit_vec};

  always_comb begin
    stat_d  = stat_q;
    stat_we = 1'b0;
    exc_d   = 1'b0;
    if (wr_stat) begin
      stat_d  = wr_data;
      stat_we = 1'b1;
    end else if (!wr_any) begin
      exc_d = armed_hit;
      if (armed_hit || force_upd) begin
        stat_d  = assembled;
        stat_we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_we) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q <= 1'b0;
    end else begin
      exc_q <= exc_d;
    end
  end

  assign status_o = stat_q;
  assign exc_o    = exc_q;

endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned SEL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [DATA_W-1:0]    insn_ptr,
  input  logic [NUM_SLOTS-1:0] watch_hit,
  input  logic                 force_upd,
  output logic [DATA_W-1:0]    status_o,
  output logic                 dbg_exc_o
);
  import dbg_bp_pkg::*;

  localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(NUM_SLOTS + 1);

  logic [1:0]                  rst_sync;
  logic                        rst_n;
  logic [NUM_SLOTS*DATA_W-1:0] addr_flat;
  logic [DATA_W-1:0]           ctrl;
  logic [NUM_SLOTS-1:0]        hit_vec;
  logic [NUM_SLOTS-1:0]        en_vec;
  logic [2*NUM_SLOTS-1:0]      kind_vec;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_n = rst_sync[1];

  dbg_bp_regs #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .addr_flat (addr_flat),
    .ctrl_o    (ctrl)
  );

  generate
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
      assign kind_vec[2*n +: 2] = ctrl[KIND_BASE + KIND_STRIDE*n +: 2];

      dbg_bp_slot #(
        .DATA_W (DATA_W)
      ) u_slot (
        .slot_addr (addr_flat[n*DATA_W +: DATA_W]),
        .insn_ptr  (insn_ptr),
        .watch     (watch_hit[n]),
        .kind      (kind_vec[2*n +: 2]),
        .en_bits   (ctrl[EN_STRIDE*n +: 2]),
        .hit       (hit_vec[n]),
        .enabled   (en_vec[n])
      );
    end
  endgenerate

  dbg_bp_status #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_any    (wr_en),
    .wr_stat   (wr_en && (wr_sel == STAT_SEL)),
    .wr_data   (wr_data),
    .hit_vec   (hit_vec),
    .en_vec    (en_vec),
    .force_upd (force_upd),
    .status_o  (status_o),
    .exc_o     (dbg_exc_o)
  );

endmodule

// File: rtl/dbg_bp_checker.sv
module dbg_bp_checker #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEL_W     = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [SEL_W-1:0]       wr_sel,
  input logic [DATA_W-1:0]      wr_data,
  input logic                   force_upd,
  input logic [NUM_SLOTS-1:0]   hit_vec,
  input logic [NUM_SLOTS-1:0]   en_vec,
  input logic [2*NUM_SLOTS-1:0] kind_vec,
  input logic [DATA_W-1:0]      status_o,
  input logic                   dbg_exc_o
);

  localparam logic [SEL_W-1:0] STAT_SEL = SEL_W'(NUM_SLOTS + 1);

  // R6: no enabled match and no force means status holds
  a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !force_upd && ((hit_vec & en_vec) == '0)) |=> $stable(status_o));

  // R7: an enabled match in a non-write cycle requests the exception
  a_r7_exc_on_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ((hit_vec & en_vec) != '0)) |=> dbg_exc_o);

  // R9: any write cycle suppresses the exception request
  a_r9_write_blocks_exc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !dbg_exc_o);

  // R9: a write to the status selector lands unchanged
  a_r9_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == STAT_SEL)) |=> (status_o == $past(wr_data)));

  // R2: upper status bits survive any non-write cycle
  a_r2_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (status_o[DATA_W-1:NUM_SLOTS] == $past(status_o[DATA_W-1:NUM_SLOTS])));

  generate
    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_io
      // R5: I/O kind never matches
      a_r5_io_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_vec[2*n +: 2] == 2'b10) |-> !hit_vec[n]);
    end
  endgenerate

endmodule

bind dbg_bp_unit dbg_bp_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .DATA_W    (DATA_W),
  .SEL_W     (SEL_W)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .force_upd (force_upd),
  .hit_vec   (hit_vec),
  .en_vec    (en_vec),
  .kind_vec  (kind_vec),
  .status_o  (status_o),
  .dbg_exc_o (dbg_exc_o)
);

// File: tb/tb_dbg_bp_unit.sv
`timescale 1ns/1ps
module tb_dbg_bp_unit;

  logic        clk;
  logic        arst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] insn_ptr;
  logic [3:0]  watch_hit;
  logic        force_upd;
  logic [31:0] status_o;
  logic        dbg_exc_o;

  dbg_bp_unit dut (
    .clk       (clk),
    .arst_n    (arst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .insn_ptr  (insn_ptr),
    .watch_hit (watch_hit),
    .force_upd (force_upd),
    .status_o  (status_o),
    .dbg_exc_o (dbg_exc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R10";

  // behavioural reference state
  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl;
  logic [31:0] m_stat;
  logic        m_exc;

  always @(posedge clk) cycles++;

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles >= 20000);
    fails++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
    report_end();
  end

  task automatic check(string req, logic [31:0] act_s, logic [31:0] exp_s,
                       logic act_e, logic exp_e);
    checks++;
    if (act_s !== exp_s || act_e !== exp_e) begin
      fails++;
      $display("FAIL %s: status actual %08h expected %08h, exc actual %0b expected %0b",
               req, act_s, exp_s, act_e, exp_e);
    end
  endtask

  // reference: one clock of the requirements
  task automatic model_step(logic w, logic [2:0] s, logic [31:0] d, logic [31:0] ip,
                            logic [3:0] wh, logic f);
    logic [3:0] hits;
    logic       armed;
    hits  = '0;
    armed = 1'b0;
    for (int n = 0; n < 4; n++) begin
      int kind;
      kind = int'(m_ctrl[16 + 4*n +: 2]);
      if (kind == 0)      hits[n] = (m_addr[n] == ip);
      else if (kind == 2) hits[n] = 1'b0;
      else                hits[n] = wh[n];
      if (hits[n] && (m_ctrl[2*n] || m_ctrl[2*n+1])) armed = 1'b1;
    end
    if (w) begin
      m_exc = 1'b0;
      if (s < 3'd4)       m_addr[s] = d;
      else if (s == 3'd4) m_ctrl = d;
      else if (s == 3'd5) m_stat = d;
    end else begin
      m_exc = armed;
      if (armed || f) m_stat = {m_stat[31:4], hits};
    end
  endtask

  // drive at negedge, step the model, compare at the following negedge
  task automatic cyc(logic w, logic [2:0] s, logic [31:0] d, logic [31:0] ip,
                     logic [3:0] wh, logic f);
    wr_en = w; wr_sel = s; wr_data = d; insn_ptr = ip; watch_hit = wh; force_upd = f;
    model_step(w, s, d, ip, wh, f);
    @(posedge clk);
    @(negedge clk);
    check(cur_req, status_o, m_stat, dbg_exc_o, m_exc);
  endtask

  task automatic wr(logic [2:0] s, logic [31:0] d);
    cyc(1'b1, s, d, 32'hFFFF_FFF0, 4'h0, 1'b0);
  endtask

  task automatic idle(logic [31:0] ip, logic [3:0] wh, logic f);
    cyc(1'b0, 3'd0, 32'h0, ip, wh, f);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = '0;
    m_ctrl = '0; m_stat = '0; m_exc = 1'b0;
    arst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    insn_ptr = 32'hFFFF_FFF0; watch_hit = '0; force_upd = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    check("R10", status_o, 32'h0, dbg_exc_o, 1'b0);

    // R3 R8: enabled instruction slot 0 (kind 00, enable bit 0)
    cur_req = "R3";
    wr(3'd0, 32'h0000_1000);
    wr(3'd4, 32'h0000_0001);
    idle(32'h0000_1000, 4'h0, 1'b0);  // status 1, exc 1
    idle(32'h0000_1004, 4'h0, 1'b0);  // no commit, exc drops
    // R2: forced commit with no match clears low bits
    cur_req = "R2";
    idle(32'h0000_1004, 4'h0, 1'b1);
    wr(3'd5, 32'hABCD_000F);
    idle(32'h0000_1000, 4'h0, 1'b0);  // expect ABCD0001

    // R6: disabled instruction slot 1 match does not commit
    cur_req = "R6";
    wr(3'd1, 32'h0000_2000);
    idle(32'h0000_2000, 4'h0, 1'b0);
    idle(32'h0000_2000, 4'h0, 1'b1);  // recorded on force, no exc
    // R1: slot 0 enabled and slot 1 disabled together
    cur_req = "R1";
    wr(3'd1, 32'h0000_1000);
    idle(32'h0000_1000, 4'h0, 1'b0);  // bits 0 and 1

    // R4 R8: slot 2 data write enabled via bit 5, slot 3 read/write via bit 6
    cur_req = "R4";
    wr(3'd4, 32'h3100_0060);
    idle(32'h0000_0000, 4'h4, 1'b0);
    idle(32'h0000_0000, 4'h8, 1'b0);
    idle(32'h0000_0000, 4'hC, 1'b0);
    cur_req = "R8";
    idle(32'h0000_0000, 4'h3, 1'b0);  // slots 0/1 disabled here: no commit

    // R5: slot 3 as I/O, address equals pointer and watch set
    cur_req = "R5";
    wr(3'd3, 32'h0000_3000);
    wr(3'd4, 32'h2000_0080);
    idle(32'h0000_3000, 4'h8, 1'b0);
    idle(32'h0000_3000, 4'h8, 1'b1);

    // R9: write collides with an enabled match, unused selectors
    cur_req = "R9";
    wr(3'd4, 32'h0000_0002);
    cyc(1'b1, 3'd6, 32'h1234_5678, 32'h0000_1000, 4'hF, 1'b1);
    cyc(1'b1, 3'd7, 32'h1234_5678, 32'h0000_1000, 4'hF, 1'b0);
    idle(32'h0000_1000, 4'h0, 1'b0);
    cyc(1'b1, 3'd5, 32'h5555_0000, 32'h0000_1000, 4'h0, 1'b0);
    idle(32'hFFFF_FFF0, 4'h0, 1'b0);

    // R7: random mixture; exception timing checked every cycle
    cur_req = "R7";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ip;
      logic        w;
      int          pick;
      pick = int'($urandom % 6);
      ip = (pick < 4) ? m_addr[pick] : $urandom;
      w  = (($urandom % 8) == 0);
      cyc(w, 3'($urandom % 8), $urandom, ip, 4'($urandom), (($urandom % 6) == 0));
    end

    report_end();
  end

endmodule